// File: doc/BRIEF.md
# Fault Capture Register Bank

This block holds one group of error-capture registers on a 64-bit configuration register bus. Its fault register gathers error pulses from hardware and keeps them as sticky bits. A mask register filters those bits. Two action registers steer each unmasked fault to one of four reporting outputs. A first-error register keeps a snapshot of the unmasked faults present when the group first goes from quiet to faulting.

Software can write the fault and mask registers in three ways. A plain write replaces the whole value. An AND-clear alias clears every bit whose data bit is zero. An OR-set alias sets every bit whose data bit is one. Single bits can therefore be changed without a read-modify-write. The bank also holds a mode register and a read-only routing status word.

Every access moves a full 8-byte word. The register index is the byte address shifted right by three. Data bit 63 is the most significant bit and is the first bit in the big-endian byte order. Index map: 0 fault, 1 fault AND-clear, 2 fault OR-set, 3 mask, 4 mask AND-clear, 5 mask OR-set, 6 action0, 7 action1, 8 first-error, 9 mode, 10 routing status. Reads of indices 0 to 2 return the fault register and reads of indices 3 to 5 return the mask register.

Top module: `errcap_bank`

## Requirements
- R1: After reset, every register reads zero and all four class outputs are low. A write to index 0 replaces the fault register with the write data.
- R2: A write to index 1 sets the fault register to the bitwise AND of its old value and the write data.
- R3: A write to index 2 sets the fault register to the bitwise OR of its old value and the write data.
- R4: The mask register works the same way: index 3 is a plain write, index 4 is an AND-clear and index 5 is an OR-set.
- R5: Action0 (index 6) and action1 (index 7) are plain read/write registers.
- R6: Any write to index 8 clears the first-error register to zero, whatever the write data.
- R7: The mode register (index 9) keeps only bits 63:56 of a write. Bits 55:0 always read zero.
- R8: Writes to the routing status word (index 10) change no register. Reading index 10 returns the class outputs in bits 3:0, in this order: bit0 checkstop, bit1 recoverable, bit2 attention, bit3 local.
- R9: The hardware error input ORs into the fault register on every clock edge. A bit raised in the same cycle as a software write to the fault register survives that write.
- R10: Each fault bit that is set and not masked goes to one class, chosen by the pair {action0[i], action1[i]}: 00 checkstop, 01 recoverable, 10 attention, 11 local. Each class output is the OR of the bits routed to it. Masked bits reach no output.
- R11: The first-error register captures the unmasked fault bits on the edge after it sees itself zero while unmasked faults exist. It then holds that value until it is cleared.
- R12: An access whose byte address has nonzero bits 2:0, or whose index is above 10, changes no register. Such a read returns zero.
- R13: A read returns its data with a valid strobe on the clock edge that samples the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe, one cycle per access |
| cfg_rd | input | 1 | Read strobe, one cycle per access |
| cfg_addr | input | AW (8) | Byte address |
| cfg_wdata | input | DW (64) | Write data, bit 63 most significant |
| cfg_rdata | output | DW (64) | Registered read data |
| cfg_rvalid | output | 1 | Read data valid |
| hw_err | input | DW (64) | Hardware error pulses, one per fault bit |
| cls_checkstop | output | 1 | OR of unmasked faults with action code 00 |
| cls_recov | output | 1 | OR of unmasked faults with action code 01 |
| cls_attn | output | 1 | OR of unmasked faults with action code 10 |
| cls_local | output | 1 | OR of unmasked faults with action code 11 |

## Verification
The bench walks one fault bit through all four action codes. A swapped bit pair in the class decode therefore raises the wrong output. It writes AND-clear data with a single zero bit, which shows whether the alias was built as a clear-where-one instead of an AND. It raises a hardware error in the same cycle as a plain write of zero, so a design that gives software priority loses the bit. It also clears the first-error register while every bit is masked, then unmasks bits with the register already set. A capture that is not gated on zero would overwrite the snapshot. Writes with misaligned and out-of-map addresses, and writes to the status word, are followed by read-backs of the registers they could have corrupted.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

  localparam int BUS_W  = 64;
  localparam int NREG   = 11;
  localparam int IDX_W  = 5;
  localparam int MODE_W = 8;

  typedef enum logic [IDX_W-1:0] {
    IX_FLT     = 5'd0,
    IX_FLT_AND = 5'd1,
    IX_FLT_OR  = 5'd2,
    IX_MSK     = 5'd3,
    IX_MSK_AND = 5'd4,
    IX_MSK_OR  = 5'd5,
    IX_ACT0    = 5'd6,
    IX_ACT1    = 5'd7,
    IX_FIRST   = 5'd8,
    IX_MODE    = 5'd9,
    IX_STAT    = 5'd10
  } reg_idx_e;

  typedef enum logic [1:0] {OP_KEEP, OP_LOAD, OP_AND, OP_OR} wr_op_e;

  typedef enum logic [1:0] {
    CL_CHECKSTOP = 2'b00,
    CL_RECOV     = 2'b01,
    CL_ATTN      = 2'b10,
    CL_LOCAL     = 2'b11
  } cls_e;

  // Next value of an alias-written register before hardware inputs join in.
  function automatic logic [BUS_W-1:0] apply_op(input wr_op_e op,
                                                input logic [BUS_W-1:0] cur,
                                                input logic [BUS_W-1:0] d);
    case (op)
      OP_LOAD: apply_op = d;
      OP_AND:  apply_op = cur & d;
      OP_OR:   apply_op = cur | d;
      default: apply_op = cur;
    endcase
  endfunction

  // Class picked by one bit's action pair; action0 is the high bit of the code.
  function automatic cls_e route_class(input logic a0, input logic a1);
    route_class = cls_e'({a0, a1});
  endfunction

endpackage

// File: rtl/errcap_addr_dec.sv
module errcap_addr_dec
  import errcap_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [AW-1:0]       cfg_addr,
  output logic [NREG-1:0]     wr_hit,
  output logic                rd_ok,
  output logic [IDX_W-1:0]    rd_idx
);
  localparam int OFF_W = 3;

  logic              aligned;
  logic              in_map;
  logic [AW-OFF_W-1:0] raw_idx;

  assign raw_idx = cfg_addr[AW-1:OFF_W];
  assign aligned = (cfg_addr[OFF_W-1:0] == '0);
  assign in_map  = (raw_idx < (AW-OFF_W)'(NREG));
  assign rd_idx  = IDX_W'(raw_idx);
  assign rd_ok   = cfg_rd && aligned && in_map;

  always_comb begin
    wr_hit = '0;
    if (cfg_wr && aligned && in_map)
      wr_hit = NREG'(1) << raw_idx;
  end
endmodule

// File: rtl/errcap_alias_reg.sv
module errcap_alias_reg
  import errcap_pkg::*;
#(
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          clr_and,
  input  logic          set_or,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_in,
  output logic [DW-1:0] q
);
  wr_op_e        op;
  logic [DW-1:0] sw_next;

  always_comb begin
    if (ld)           op = OP_LOAD;
    else if (clr_and) op = OP_AND;
    else if (set_or)  op = OP_OR;
    else              op = OP_KEEP;
    sw_next = DW'(apply_op(op, BUS_W'(q), BUS_W'(wdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= sw_next | hw_in;
  end
endmodule

// File: rtl/errcap_route.sv
module errcap_route
  import errcap_pkg::*;
#(
  parameter int DW = BUS_W
) (
  input  logic [DW-1:0] active,
  input  logic [DW-1:0] act0,
  input  logic [DW-1:0] act1,
  output logic [3:0]    cls_out
);
  logic [DW-1:0] to_cs, to_rc, to_at, to_lc;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    cls_e c;
    assign c        = route_class(act0[i], act1[i]);
    assign to_cs[i] = active[i] && (c == CL_CHECKSTOP);
    assign to_rc[i] = active[i] && (c == CL_RECOV);
    assign to_at[i] = active[i] && (c == CL_ATTN);
    assign to_lc[i] = active[i] && (c == CL_LOCAL);
  end

  assign cls_out = {|to_lc, |to_at, |to_rc, |to_cs};
endmodule

// File: rtl/errcap_first.sv
module errcap_first
  import errcap_pkg::*;
#(
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] unmasked,
  output logic [DW-1:0] q,
  output logic          capture_ev
);
  assign capture_ev = !clr && (q == '0) && (unmasked != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr)        q <= '0;
    else if (capture_ev) q <= unmasked;
  end
endmodule

// File: rtl/errcap_bank.sv
module errcap_bank
  import errcap_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          cfg_rvalid,
  input  logic [DW-1:0] hw_err,
  output logic          cls_checkstop,
  output logic          cls_recov,
  output logic          cls_attn,
  output logic          cls_local
);
  localparam logic [DW-1:0] MODE_KEEP = {{MODE_W{1'b1}}, {(DW-MODE_W){1'b0}}};

  logic [NREG-1:0]  wr_hit;
  logic             rd_ok;
  logic [IDX_W-1:0] rd_idx;
  logic [DW-1:0]    fault_q, mask_q, act0_q, act1_q, first_q, mode_q;
  logic [DW-1:0]    unmasked;
  logic [3:0]       cls_vec;
  logic             first_clr;
  logic             capture_ev;
  logic [DW-1:0]    rd_mux;

  errcap_addr_dec #(.AW(AW)) u_dec (
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .wr_hit(wr_hit), .rd_ok(rd_ok), .rd_idx(rd_idx)
  );

  errcap_alias_reg #(.DW(DW)) u_fault (
    .clk(clk), .rst_n(rst_n),
    .ld(wr_hit[IX_FLT]), .clr_and(wr_hit[IX_FLT_AND]), .set_or(wr_hit[IX_FLT_OR]),
    .wdata(cfg_wdata), .hw_in(hw_err), .q(fault_q)
  );

  errcap_alias_reg #(.DW(DW)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .ld(wr_hit[IX_MSK]), .clr_and(wr_hit[IX_MSK_AND]), .set_or(wr_hit[IX_MSK_OR]),
    .wdata(cfg_wdata), .hw_in('0), .q(mask_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act0_q <= '0;
      act1_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_hit[IX_ACT0]) act0_q <= cfg_wdata;
      if (wr_hit[IX_ACT1]) act1_q <= cfg_wdata;
      if (wr_hit[IX_MODE]) mode_q <= cfg_wdata & MODE_KEEP;
    end
  end

  assign unmasked  = fault_q & ~mask_q;
  assign first_clr = wr_hit[IX_FIRST];

  errcap_first #(.DW(DW)) u_first (
    .clk(clk), .rst_n(rst_n), .clr(first_clr), .unmasked(unmasked),
    .q(first_q), .capture_ev(capture_ev)
  );

  errcap_route #(.DW(DW)) u_route (
    .active(unmasked), .act0(act0_q), .act1(act1_q), .cls_out(cls_vec)
  );

  assign cls_checkstop = cls_vec[0];
  assign cls_recov     = cls_vec[1];
  assign cls_attn      = cls_vec[2];
  assign cls_local     = cls_vec[3];

  always_comb begin
    rd_mux = '0;
    case (rd_idx)
      IX_FLT, IX_FLT_AND, IX_FLT_OR: rd_mux = fault_q;
      IX_MSK, IX_MSK_AND, IX_MSK_OR: rd_mux = mask_q;
      IX_ACT0:  rd_mux = act0_q;
      IX_ACT1:  rd_mux = act1_q;
      IX_FIRST: rd_mux = first_q;
      IX_MODE:  rd_mux = mode_q;
      IX_STAT:  rd_mux = DW'(cls_vec);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= cfg_rd;
      cfg_rdata  <= rd_ok ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/errcap_bank_chk.sv
module errcap_bank_chk #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [AW-1:0] cfg_addr,
  input logic [DW-1:0] cfg_wdata,
  input logic [DW-1:0] hw_err,
  input logic [DW-1:0] fault_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] act0_q,
  input logic [DW-1:0] act1_q,
  input logic [DW-1:0] first_q,
  input logic [DW-1:0] mode_q,
  input logic [DW-1:0] unmasked,
  input logic          first_clr,
  input logic          cls_checkstop,
  input logic          cls_recov,
  input logic          cls_attn,
  input logic          cls_local
);
  a_r9_hw_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_err != '0) |=> ((fault_q & $past(hw_err)) == $past(hw_err)));

  a_r6_first_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    first_clr |=> (first_q == '0));

  a_r11_first_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((first_q != '0) && !first_clr) |=> $stable(first_q));

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (unmasked == '0) |-> !(cls_checkstop || cls_recov || cls_attn || cls_local));

  a_r7_mode_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[DW-9:0] == '0);

  a_r12_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_addr[2:0] != 3'd0)) |=>
      ($stable(mask_q) && $stable(act0_q) && $stable(act1_q) && $stable(mode_q)));
endmodule

bind errcap_bank errcap_bank_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .hw_err(hw_err), .fault_q(fault_q), .mask_q(mask_q),
  .act0_q(act0_q), .act1_q(act1_q), .first_q(first_q), .mode_q(mode_q),
  .unmasked(unmasked), .first_clr(first_clr), .cls_checkstop(cls_checkstop),
  .cls_recov(cls_recov), .cls_attn(cls_attn), .cls_local(cls_local)
);

// File: tb/sim_errcap_bank.sv
module sim_errcap_bank;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int DW = 64;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0, hw_err = '0;
  logic [DW-1:0] cfg_rdata;
  logic          cfg_rvalid;
  logic          cls_checkstop, cls_recov, cls_attn, cls_local;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  errcap_bank #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .hw_err(hw_err), .cls_checkstop(cls_checkstop),
    .cls_recov(cls_recov), .cls_attn(cls_attn), .cls_local(cls_local)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares each returned read against the scoreboard head.
  always @(negedge clk) begin
    if (cfg_rvalid) begin
      if (exp_q.size() == 0) check("R13 unexpected read data", 64'd1, 64'd0);
      else check(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
    end
  end

  task automatic wr_raw(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [63:0] d);
    wr_raw(AW'(idx << 3), d);
  endtask

  task automatic rd(input int idx, input logic [63:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = AW'(idx << 3);
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  function automatic logic [63:0] cls_word();
    return {60'd0, cls_local, cls_attn, cls_recov, cls_checkstop};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog all-requirements actual=hung expected=complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 reset class outputs", cls_word(), 64'd0);
    rd(0, 64'd0, "R1 reset fault");
    rd(3, 64'd0, "R1 reset mask");
    rd(8, 64'd0, "R1 reset first-error");
    // R4 mask: plain, AND-clear, OR-set
    wr(3, ONES);                 rd(3, ONES, "R4 mask plain");
    wr(4, ~64'h0F);              rd(5, ONES & ~64'h0F, "R4 mask AND-clear");
    wr(5, 64'h01);               rd(4, ~64'h0E, "R4 mask OR-set");
    // R1 plain fault write; unmasked bit 2 routes to checkstop
    wr(0, 64'hA5);               rd(0, 64'hA5, "R1 fault plain write");
    check("R10 code 00 checkstop", cls_word(), 64'h1);
    rd(8, 64'h04, "R11 first-error capture");
    // R2 AND-clear with one zero bit
    wr(1, ~64'h04);              rd(2, 64'hA1, "R2 fault AND-clear");
    check("R10 no unmasked faults", cls_word(), 64'h0);
    // R3 OR-set
    wr(2, 64'h08);               rd(1, 64'hA9, "R3 fault OR-set");
    rd(8, 64'h04, "R11 first-error holds");
    // R5 / R10 action codes on bit 3
    wr(6, 64'h08);               rd(6, 64'h08, "R5 action0 readback");
    check("R10 code 10 attention", cls_word(), 64'h4);
    wr(7, 64'h08);               rd(7, 64'h08, "R5 action1 readback");
    check("R10 code 11 local", cls_word(), 64'h8);
    wr(6, 64'h00);
    check("R10 code 01 recoverable", cls_word(), 64'h2);
    rd(10, 64'h2, "R8 status word");
    // R6 clear first-error with everything masked
    wr(3, ONES);
    check("R10 all masked quiet", cls_word(), 64'h0);
    wr(8, ONES);                 rd(8, 64'd0, "R6 first-error cleared");
    // R7 mode keeps top byte only
    wr(9, ONES);                 rd(9, 64'hFF00_0000_0000_0000, "R7 mode top byte");
    // R8 status writes ignored
    wr(10, ONES);
    rd(0, 64'hA9, "R8 fault after status write");
    rd(3, ONES, "R8 mask after status write");
    rd(7, 64'h08, "R8 action1 after status write");
    // R12 misaligned and out-of-map accesses
    wr_raw(8'h01, 64'h0);        rd(0, 64'hA9, "R12 misaligned write fault");
    wr_raw(8'h1B, 64'h0);        rd(3, ONES, "R12 misaligned write mask");
    wr(15, ONES);                rd(15, 64'd0, "R12 out-of-map read");
    // R9 hardware error alongside plain write of zero
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h00; cfg_wdata = 64'd0; hw_err = 64'd1 << 40;
    @(negedge clk);
    cfg_wr = 1'b0; hw_err = 64'd0;
    rd(0, 64'd1 << 40, "R9 hw error survives write");
    @(negedge clk); hw_err = 64'd1 << 50;
    @(negedge clk); hw_err = 64'd0;
    rd(0, (64'd1 << 40) | (64'd1 << 50), "R9 hw error accumulates");
    // R11 capture after unmask, then hold when more bits unmask
    wr(3, ~(64'd1 << 50));
    @(negedge clk);
    rd(8, 64'd1 << 50, "R11 capture on unmask");
    wr(3, 64'd0);
    rd(8, 64'd1 << 50, "R11 hold after further unmask");
    repeat (3) @(negedge clk);
    check("R13 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule